// File: doc/BRIEF.md
# Masked-Key Associative Translation Lookup

This block turns a plain row-organized RAM into a two-way set-associative translation table. A key, for example an object name or a class concatenated with a selector, is mapped to a table row by a configurable base/mask register. Each mask bit decides whether the matching row address bit comes from the key or from the base. The table can therefore be placed anywhere in the row space and given any power-of-two size without extra hardware. Every row holds four words as two key/value pairs. On a lookup, all key words of the selected row are compared with the full probe key at once, and the value word paired with the matching key is returned.

A lookup is issued with a one-cycle strobe. Its result appears in the following cycle as exactly one of hit or miss, together with the value. A miss is meant to let the surrounding processor trap and run its own refill code. New key/value pairs are entered with an insert command. The insert uses the first free pair of the selected row. When the row is full, a one-bit pointer kept per row picks the pair to overwrite, alternating between the two pairs.

Top module: `assoc_xlate`

## Requirements
- R1: After reset, res_hit and res_miss are low, res_data is zero, and every pair of every row is empty, so any lookup misses until a pair is inserted.
- R2: The row address is formed bit by bit as mask[i] ? key[i] : base[i] over a 14-bit address, and the row is the upper 10 bits of it (address bits 13:4). A write to the base/mask register applies to requests in later cycles; a request in the same cycle as the write uses the previous setting.
- R3: A lookup strobed at one clock edge produces its result in the cycle after that edge, with exactly one of res_hit and res_miss high; in any cycle not following a strobe both are low.
- R4: On a hit, res_data carries the value stored with the matching key. On a miss or an idle cycle, res_data is zero.
- R5: Key comparison uses all 36 bits of the word, including the tag bits 35:32; a probe that differs in any single bit does not hit.
- R6: An insert writes its pair into the lowest-numbered empty pair of the selected row (pair 0 before pair 1).
- R7: When both pairs of the selected row are full, an insert overwrites the pair named by that row's pointer, which starts at pair 0 and toggles on every overwrite only; a fill into an empty pair leaves the pointer unchanged.
- R8: A lookup issued in the same cycle as an insert sees the table as it was before that insert.
- R9: If more than one pair of a row matches the probe, the value of the lowest-numbered matching pair is returned.
- R10: Inserting into one row changes neither the pairs nor the replacement pointer of any other row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the base/mask register |
| cfg_base | input | 14 | Base bits used where the mask bit is 0 |
| cfg_mask | input | 14 | Per-bit selector: 1 takes the key bit, 0 takes the base bit |
| lk_req | input | 1 | Lookup strobe |
| lk_key | input | 36 | Key to translate |
| ins_req | input | 1 | Insert strobe |
| ins_key | input | 36 | Key word of the pair to insert |
| ins_data | input | 36 | Value word of the pair to insert |
| res_hit | output | 1 | Lookup of the previous cycle matched |
| res_miss | output | 1 | Lookup of the previous cycle found no match |
| res_data | output | 36 | Value of the matching pair, zero otherwise |

## Verification
A wrong row address or a stale base/mask setting appears at the next lookup as a miss for a key that was just entered, or as a hit in the wrong table region. That lookup returns its result one cycle after the strobe. A broken empty-pair flag or replacement pointer stays hidden until a row fills up. It then shows as the wrong survivor after the third and fourth inserts into the same row. The scenarios are therefore built around filling one row several times over, moving the table with base and mask, and probing keys that differ only in tag or low bits. Corruption in one row must not leak into the results of another.

// File: rtl/assoc_xlate_pkg.sv
package assoc_xlate_pkg;

  // What an insert does to the selected row.
  typedef enum logic [1:0] {
    INS_NONE    = 2'd0,
    INS_FILL    = 2'd1,
    INS_REPLACE = 2'd2
  } ins_kind_e;

  // Width of a pointer that names one of n pairs (at least one bit).
  function automatic int unsigned ptr_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xl_row_former.sv
// Builds the row index: each bit comes from the key where the mask is set,
// otherwise from the base.
module xl_row_former #(
  parameter int unsigned ROW_W = 10
) (
  input  logic [ROW_W-1:0] key_bits,
  input  logic [ROW_W-1:0] base_bits,
  input  logic [ROW_W-1:0] mask_bits,
  output logic [ROW_W-1:0] row
);
  for (genvar i = 0; i < ROW_W; i++) begin : g_bit
    assign row[i] = mask_bits[i] ? key_bits[i] : base_bits[i];
  end
endmodule

// File: rtl/xl_pair_ram.sv
// One key/value pair column of the table: simple dual-port RAM, synchronous
// read-first, written so that block RAM can be inferred.
module xl_pair_ram #(
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned DATA_W = 72
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ROW_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xl_slot_state.sv
// Per-row occupancy flags and replacement pointers; chooses the pair an
// insert writes and snapshots occupancy for a lookup (before any same-cycle insert).
module xl_slot_state
  import assoc_xlate_pkg::*;
#(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned PAIRS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_req,
  input  logic [ROW_W-1:0] ins_row,
  input  logic             lk_req,
  input  logic [ROW_W-1:0] lk_row,
  output logic [PAIRS-1:0] wr_en,
  output logic [PAIRS-1:0] lk_valid
);
  localparam int unsigned ROWS  = 1 << ROW_W;
  localparam int unsigned PTR_W = ptr_width(PAIRS);

  logic [PAIRS-1:0] valid_q [ROWS];
  logic [PTR_W-1:0] rr_q    [ROWS];

  logic [PAIRS-1:0] cur_valid;
  logic [PTR_W-1:0] cur_rr;
  logic             free_found;
  logic [PTR_W-1:0] free_idx;
  logic [PTR_W-1:0] victim;
  ins_kind_e        kind;

  assign cur_valid = valid_q[ins_row];
  assign cur_rr    = rr_q[ins_row];

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int p = 0; p < PAIRS; p++) begin
      if (!free_found && !cur_valid[p]) begin
        free_found = 1'b1;
        free_idx   = PTR_W'(p);
      end
    end
  end

  always_comb begin
    if (!ins_req)        kind = INS_NONE;
    else if (free_found) kind = INS_FILL;
    else                 kind = INS_REPLACE;
  end

  assign victim = (kind == INS_FILL) ? free_idx : cur_rr;

  always_comb begin
    wr_en = '0;
    if (kind != INS_NONE) wr_en[victim] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) begin
        valid_q[r] <= '0;
        rr_q[r]    <= '0;
      end
      lk_valid <= '0;
    end else begin
      if (lk_req) lk_valid <= valid_q[lk_row];
      if (kind != INS_NONE) valid_q[ins_row][victim] <= 1'b1;
      if (kind == INS_REPLACE) begin
        if (cur_rr == PTR_W'(PAIRS - 1)) rr_q[ins_row] <= '0;
        else                             rr_q[ins_row] <= cur_rr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xl_match.sv
// Compares the probe key with every key word of the row; the lowest
// matching pair supplies the value.
module xl_match #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned PAIRS  = 2
) (
  input  logic [WORD_W-1:0]         probe,
  input  logic [PAIRS*2*WORD_W-1:0] row_words,
  input  logic [PAIRS-1:0]          valid,
  output logic                      hit,
  output logic [WORD_W-1:0]         value
);
  localparam int unsigned PAIR_W = 2 * WORD_W;

  logic [PAIRS-1:0] eq;

  for (genvar p = 0; p < PAIRS; p++) begin : g_cmp
    assign eq[p] = valid[p] &&
                   (row_words[p*PAIR_W + WORD_W +: WORD_W] == probe);
  end

  always_comb begin
    hit   = 1'b0;
    value = '0;
    for (int p = 0; p < PAIRS; p++) begin
      if (!hit && eq[p]) begin
        hit   = 1'b1;
        value = row_words[p*PAIR_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/assoc_xlate.sv
module assoc_xlate #(
  parameter int unsigned WORD_W    = 36,
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned ROW_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              lk_req,
  input  logic [WORD_W-1:0] lk_key,
  input  logic              ins_req,
  input  logic [WORD_W-1:0] ins_key,
  input  logic [WORD_W-1:0] ins_data,
  output logic              res_hit,
  output logic              res_miss,
  output logic [WORD_W-1:0] res_data
);
  localparam int unsigned PAIRS   = ROW_WORDS / 2;
  localparam int unsigned PAIR_W  = 2 * WORD_W;
  localparam int unsigned ROW_LSB = ADDR_W - ROW_W;

  // Base/mask register: only the bits that reach the row index are kept.
  logic [ROW_W-1:0] base_q, mask_q;
  logic             cfg_lo_unused;

  assign cfg_lo_unused = ^{cfg_base[ROW_LSB-1:0], cfg_mask[ROW_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      base_q <= cfg_base[ADDR_W-1:ROW_LSB];
      mask_q <= cfg_mask[ADDR_W-1:ROW_LSB];
    end
  end

  logic [ROW_W-1:0] lk_row, ins_row;

  xl_row_former #(.ROW_W(ROW_W)) u_lk_row (
    .key_bits (lk_key[ADDR_W-1:ROW_LSB]),
    .base_bits(base_q),
    .mask_bits(mask_q),
    .row      (lk_row)
  );

  xl_row_former #(.ROW_W(ROW_W)) u_ins_row (
    .key_bits (ins_key[ADDR_W-1:ROW_LSB]),
    .base_bits(base_q),
    .mask_bits(mask_q),
    .row      (ins_row)
  );

  logic [PAIRS-1:0] wr_en, lk_valid;

  xl_slot_state #(.ROW_W(ROW_W), .PAIRS(PAIRS)) u_slots (
    .clk     (clk),
    .rst     (rst),
    .ins_req (ins_req),
    .ins_row (ins_row),
    .lk_req  (lk_req),
    .lk_row  (lk_row),
    .wr_en   (wr_en),
    .lk_valid(lk_valid)
  );

  // Pair p occupies words 2p (value) and 2p+1 (key) of a row.
  logic [PAIRS*PAIR_W-1:0] row_words;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    xl_pair_ram #(.ROW_W(ROW_W), .DATA_W(PAIR_W)) u_ram (
      .clk  (clk),
      .we   (wr_en[p]),
      .waddr(ins_row),
      .wdata({ins_key, ins_data}),
      .re   (lk_req),
      .raddr(lk_row),
      .rdata(row_words[p*PAIR_W +: PAIR_W])
    );
  end

  logic              pend_q;
  logic [WORD_W-1:0] probe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      probe_q <= '0;
    end else begin
      pend_q <= lk_req;
      if (lk_req) probe_q <= lk_key;
    end
  end

  logic              any_hit;
  logic [WORD_W-1:0] hit_value;

  xl_match #(.WORD_W(WORD_W), .PAIRS(PAIRS)) u_match (
    .probe    (probe_q),
    .row_words(row_words),
    .valid    (lk_valid),
    .hit      (any_hit),
    .value    (hit_value)
  );

  assign res_hit  = pend_q && any_hit;
  assign res_miss = pend_q && !any_hit;
  assign res_data = res_hit ? hit_value : '0;
endmodule

// File: rtl/assoc_xlate_chk.sv
module assoc_xlate_chk #(
  parameter int unsigned WORD_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_req,
  input logic              res_hit,
  input logic              res_miss,
  input logic [WORD_W-1:0] res_data
);
  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
    !(res_hit && res_miss));

  assert_result_after_req_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(lk_req) && !$past(rst)) |-> (res_hit || res_miss));

  assert_quiet_without_req_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(lk_req) |-> (!res_hit && !res_miss));

  assert_zero_data_R4: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_data == '0));

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_hit && !res_miss));
endmodule

bind assoc_xlate assoc_xlate_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .lk_req  (lk_req),
  .res_hit (res_hit),
  .res_miss(res_miss),
  .res_data(res_data)
);

// File: tb/assoc_xlate_tb_top.sv
`timescale 1ns/1ps
module assoc_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [13:0] cfg_base = '0, cfg_mask = '0;
  logic        lk_req = 1'b0;
  logic [35:0] lk_key = '0;
  logic        ins_req = 1'b0;
  logic [35:0] ins_key = '0, ins_data = '0;
  logic        res_hit, res_miss;
  logic [35:0] res_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assoc_xlate dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .lk_req(lk_req), .lk_key(lk_key),
    .ins_req(ins_req), .ins_key(ins_key), .ins_data(ins_data),
    .res_hit(res_hit), .res_miss(res_miss), .res_data(res_data)
  );

  task automatic check(input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lk_req = 1'b0; ins_req = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cfg(input logic [13:0] base, input logic [13:0] mask);
    @(negedge clk);
    cfg_we = 1'b1; cfg_base = base; cfg_mask = mask;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic insert(input logic [35:0] key, input logic [35:0] val);
    @(negedge clk);
    ins_req = 1'b1; ins_key = key; ins_data = val;
    @(negedge clk);
    ins_req = 1'b0;
  endtask

  task automatic lookup(input logic [35:0] key);
    @(negedge clk);
    lk_req = 1'b1; lk_key = key;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [35:0] key,
                            input logic [35:0] val);
    lookup(key);
    check(req, "hit", {35'd0, res_hit}, 36'd1);
    check(req, "miss", {35'd0, res_miss}, 36'd0);
    check(req, "data", res_data, val);
  endtask

  task automatic expect_miss(input string req, input logic [35:0] key);
    lookup(key);
    check(req, "hit", {35'd0, res_hit}, 36'd0);
    check(req, "miss", {35'd0, res_miss}, 36'd1);
    check(req, "data", res_data, 36'd0);
  endtask

  // R1 / R3: reset state, idle outputs, table emptied by reset
  task automatic t_reset_state();
    do_reset();
    check("R1", "hit after reset", {35'd0, res_hit}, 36'd0);
    check("R1", "miss after reset", {35'd0, res_miss}, 36'd0);
    check("R1", "data after reset", res_data, 36'd0);
    expect_miss("R1", 36'h0_0000_0000);
    set_cfg(14'h0000, 14'h0000);
    insert(36'h1_0000_0042, 36'hA_AAAA_0001);
    expect_hit("R4", 36'h1_0000_0042, 36'hA_AAAA_0001);
    do_reset();
    expect_miss("R1", 36'h1_0000_0042);
    @(negedge clk);
    check("R3", "idle hit", {35'd0, res_hit}, 36'd0);
    check("R3", "idle miss", {35'd0, res_miss}, 36'd0);
  endtask

  // R6 / R7: fill one row, then replace round-robin
  task automatic t_fill_and_replace();
    do_reset();
    set_cfg(14'h1230, 14'h0000);
    insert(36'h0_0000_0A00, 36'h0_0000_D00A);
    insert(36'h0_0000_0B00, 36'h0_0000_D00B);
    expect_hit("R6", 36'h0_0000_0A00, 36'h0_0000_D00A);
    expect_hit("R6", 36'h0_0000_0B00, 36'h0_0000_D00B);
    expect_miss("R4", 36'h0_0000_0C00);
    insert(36'h0_0000_0C00, 36'h0_0000_D00C);
    expect_miss("R7", 36'h0_0000_0A00);
    expect_hit("R7", 36'h0_0000_0B00, 36'h0_0000_D00B);
    expect_hit("R7", 36'h0_0000_0C00, 36'h0_0000_D00C);
    insert(36'h0_0000_0D00, 36'h0_0000_D00D);
    expect_miss("R7", 36'h0_0000_0B00);
    expect_hit("R7", 36'h0_0000_0C00, 36'h0_0000_D00C);
    insert(36'h0_0000_0E00, 36'h0_0000_D00E);
    expect_miss("R7", 36'h0_0000_0C00);
    expect_hit("R7", 36'h0_0000_0D00, 36'h0_0000_D00D);
    expect_hit("R7", 36'h0_0000_0E00, 36'h0_0000_D00E);
  endtask

  // R2 / R10: key bits select rows; base moves the table; rows independent
  task automatic t_row_select();
    do_reset();
    set_cfg(14'h0000, 14'h3FF0);
    insert(36'h0_0000_0010, 36'h0_0000_1111);
    insert(36'h0_0000_0020, 36'h0_0000_2222);
    insert(36'h0_0000_0030, 36'h0_0000_3333);
    expect_hit("R2", 36'h0_0000_0010, 36'h0_0000_1111);
    expect_hit("R2", 36'h0_0000_0020, 36'h0_0000_2222);
    expect_hit("R2", 36'h0_0000_0030, 36'h0_0000_3333);
    insert(36'h0_0000_0011, 36'h0_0000_1112);
    insert(36'h0_0000_0012, 36'h0_0000_1113);
    expect_miss("R10", 36'h0_0000_0010);
    expect_hit("R10", 36'h0_0000_0011, 36'h0_0000_1112);
    expect_hit("R10", 36'h0_0000_0020, 36'h0_0000_2222);
    expect_hit("R10", 36'h0_0000_0030, 36'h0_0000_3333);
    insert(36'h0_0000_0021, 36'h0_0000_2223);
    insert(36'h0_0000_0022, 36'h0_0000_2224);
    expect_miss("R10", 36'h0_0000_0020);
    expect_hit("R10", 36'h0_0000_0021, 36'h0_0000_2223);
    set_cfg(14'h0020, 14'h0000);
    expect_hit("R2", 36'h0_0000_0022, 36'h0_0000_2224);
    expect_miss("R2", 36'h0_0000_0011);
  endtask

  // R2: a lookup in the cycle of a config write uses the old setting
  task automatic t_cfg_timing();
    do_reset();
    set_cfg(14'h0100, 14'h0000);
    insert(36'h0_0000_0077, 36'h0_0000_7777);
    @(negedge clk);
    cfg_we = 1'b1; cfg_base = 14'h0200; cfg_mask = 14'h0000;
    lk_req = 1'b1; lk_key = 36'h0_0000_0077;
    @(negedge clk);
    cfg_we = 1'b0; lk_req = 1'b0;
    check("R2", "old cfg hit", {35'd0, res_hit}, 36'd1);
    check("R2", "old cfg data", res_data, 36'h0_0000_7777);
    expect_miss("R2", 36'h0_0000_0077);
  endtask

  // R5: full-width comparison including tag bits
  task automatic t_tag_compare();
    do_reset();
    set_cfg(14'h0000, 14'h0000);
    insert(36'h3_0000_0ABC, 36'h0_1234_5678);
    expect_miss("R5", 36'h1_0000_0ABC);
    expect_miss("R5", 36'h3_0000_0ABD);
    expect_miss("R5", 36'hB_0000_0ABC);
    expect_hit("R5", 36'h3_0000_0ABC, 36'h0_1234_5678);
  endtask

  // R8: same-cycle insert and lookup
  task automatic t_read_first();
    do_reset();
    set_cfg(14'h0000, 14'h0000);
    @(negedge clk);
    ins_req = 1'b1; ins_key = 36'h0_0000_0555; ins_data = 36'h0_0000_0AAA;
    lk_req = 1'b1; lk_key = 36'h0_0000_0555;
    @(negedge clk);
    ins_req = 1'b0; lk_req = 1'b0;
    check("R8", "same-cycle hit", {35'd0, res_hit}, 36'd0);
    check("R8", "same-cycle miss", {35'd0, res_miss}, 36'd1);
    expect_hit("R8", 36'h0_0000_0555, 36'h0_0000_0AAA);
  endtask

  // R9: duplicate keys resolve to the lowest pair
  task automatic t_duplicate();
    do_reset();
    set_cfg(14'h0000, 14'h0000);
    insert(36'h0_0000_0900, 36'h0_0000_0001);
    insert(36'h0_0000_0900, 36'h0_0000_0002);
    expect_hit("R9", 36'h0_0000_0900, 36'h0_0000_0001);
    insert(36'h0_0000_0901, 36'h0_0000_0003);
    expect_hit("R9", 36'h0_0000_0900, 36'h0_0000_0002);
    expect_hit("R9", 36'h0_0000_0901, 36'h0_0000_0003);
  endtask

  initial begin
    t_reset_state();
    t_fill_and_replace();
    t_row_select();
    t_cfg_timing();
    t_tag_compare();
    t_read_first();
    t_duplicate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R3 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule